// File: doc/BRIEF.md
# Gated Reference Frequency Error Counter

This block measures how far a local reference clock is from its nominal frequency, using a one-pulse-per-second timing line as the yardstick. A timebase counter runs on the reference clock and is never cleared. It wraps around at the end of its range. Each rising edge of the pulse line, after synchronization, copies the timebase into a capture register. Every `GATE_EDGES` pulse edges, the capture at the gate boundary is subtracted from the one at the previous boundary, modulo the counter range. The nominal cycle total for the gate is then removed, which gives a signed error count.

With the defaults (32-bit timebase, 10 MHz reference, 100-edge gate, 1,000,000,000 nominal cycles), one count of error is one part per billion. A positive value means the reference runs fast. The error is published with a one-cycle valid strobe. The latest raw capture is also exposed for debug.

Top module: `pps_freq_err`

## Requirements
- R1: The timebase counts up by one every reference cycle and is never cleared by a pulse edge. `rawCapture` advances between consecutive captures by exactly the number of reference cycles between the corresponding pulse edges, modulo 2^CNT_W.
- R2: Exactly one capture happens per rising edge of `ppsIn`. A line held high for many cycles, or held low, causes no further captures.
- R3: `errValid` pulses once per gate boundary, and a boundary is every `GATE_EDGES`-th pulse edge counted from the first edge after reset (0-based edges 0, N, 2N, ...). The pulse appears before the next pulse edge.
- R4: The first boundary after reset only primes the previous-boundary capture. No `errValid` is produced there, so the first valid comes at edge index N.
- R5: `errOut` equals (boundary capture minus previous boundary capture) minus `NOMINAL`, as a CNT_W-bit two's-complement value. It is positive when more cycles than nominal elapsed.
- R6: Wraparound of the timebase between the two boundary captures does not disturb `errOut` or `rawCapture` differences.
- R7: While and directly after `rst`, `errValid` is 0, `errOut` is 0 and `rawCapture` is 0. A reset also restarts the gate and the priming.
- R8: `errValid` is never high two cycles in a row, and `errOut` changes only in a cycle where `errValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, drives the timebase |
| rst | input | 1 | Synchronous active-high reset |
| ppsIn | input | 1 | Asynchronous one-pulse-per-second timing line |
| errOut | output | CNT_W | Signed frequency error count of the last complete gate |
| errValid | output | 1 | One-cycle strobe marking a new `errOut` |
| rawCapture | output | CNT_W | Timebase value captured at the latest pulse edge |

## Verification
The hardest situation to reach from the ports is a gate whose two boundary captures straddle a timebase wrap. This is combined with per-interval spacings that are uneven but still sum to a known total. The bench shrinks the timebase to 12 bits and the gate to 4 edges, so wraps happen every few gates. It then drives pulse trains with exact, fast, slow, uneven and long-high spacings. Every expected error is computed from the bench's own record of the cycles at which it raised the line. A reset in mid-run checks that priming starts over.

// File: rtl/pps_freq_err_pkg.sv
package pps_freq_err_pkg;

  // Strobes passed from control to datapath, one cycle wide
  typedef struct packed {
    logic capture;   // synchronized rising edge of the pulse line
    logic gateEnd;   // this edge is a gate boundary
    logic primed;    // a previous boundary capture exists
  } ctlStrb_t;

endpackage

// File: rtl/pps_ctl.sv
module pps_ctl
  import pps_freq_err_pkg::*;
#(
  parameter int GATE_EDGES = 100
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ppsIn,
  output ctlStrb_t strb
);

  localparam int IDX_W = (GATE_EDGES > 1) ? $clog2(GATE_EDGES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(GATE_EDGES - 1);

  logic ppsMeta, ppsSync, ppsDly;
  logic rise;
  logic [IDX_W-1:0] edgeIdx;
  logic primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      ppsMeta <= 1'b0;
      ppsSync <= 1'b0;
      ppsDly  <= 1'b0;
    end else begin
      ppsMeta <= ppsIn;
      ppsSync <= ppsMeta;
      ppsDly  <= ppsSync;
    end
  end

  assign rise = ppsSync & ~ppsDly;

  always_ff @(posedge clk) begin
    if (rst) begin
      edgeIdx <= '0;
      primed  <= 1'b0;
    end else if (rise) begin
      edgeIdx <= (edgeIdx == IDX_LAST) ? '0 : edgeIdx + 1'b1;
      if (edgeIdx == '0) primed <= 1'b1;
    end
  end

  always_comb begin
    strb.capture = rise;
    strb.gateEnd = rise && (edgeIdx == '0);
    strb.primed  = primed;
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R2
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    edgeIdx <= IDX_LAST); // R3
  AST_PRIME_AFTER_GATE: assert property (@(posedge clk) disable iff (rst)
    strb.gateEnd |=> strb.primed); // R4

endmodule

// File: rtl/pps_dp.sv
module pps_dp
  import pps_freq_err_pkg::*;
#(
  parameter int          CNT_W   = 32,
  parameter int unsigned NOMINAL = 32'd1_000_000_000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctlStrb_t                strb,
  output logic signed [CNT_W-1:0] errOut,
  output logic                    errValid,
  output logic        [CNT_W-1:0] rawCapture
);

  localparam logic [CNT_W-1:0] NOM_W = CNT_W'(NOMINAL);

  logic [CNT_W-1:0] timebase;
  logic [CNT_W-1:0] prevGateCap;
  logic [CNT_W-1:0] gateDelta;

  always_ff @(posedge clk) begin
    if (rst) timebase <= '0;
    else     timebase <= timebase + 1'b1;
  end

  // modular difference; wrap between boundaries is harmless
  assign gateDelta = timebase - prevGateCap;

  always_ff @(posedge clk) begin
    if (rst) begin
      rawCapture  <= '0;
      prevGateCap <= '0;
      errOut      <= '0;
      errValid    <= 1'b0;
    end else begin
      errValid <= 1'b0;
      if (strb.capture) rawCapture <= timebase;
      if (strb.gateEnd) begin
        prevGateCap <= timebase;
        if (strb.primed) begin
          errOut   <= $signed(gateDelta - NOM_W);
          errValid <= 1'b1;
        end
      end
    end
  end

  AST_COUNTER_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> timebase == $past(timebase) + 1'b1); // R1
  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (rst)
    strb.capture |=> rawCapture == $past(timebase)); // R1
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    errValid |=> !errValid); // R8
  AST_ERR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !errValid |-> $stable(errOut)); // R8

endmodule

// File: rtl/pps_freq_err.sv
module pps_freq_err
  import pps_freq_err_pkg::*;
#(
  parameter int          CNT_W      = 32,
  parameter int          GATE_EDGES = 100,
  parameter int unsigned NOMINAL    = 32'd1_000_000_000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ppsIn,
  output logic signed [CNT_W-1:0] errOut,
  output logic                    errValid,
  output logic        [CNT_W-1:0] rawCapture
);

  ctlStrb_t strb;

  pps_ctl #(.GATE_EDGES(GATE_EDGES)) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .ppsIn (ppsIn),
    .strb  (strb)
  );

  pps_dp #(.CNT_W(CNT_W), .NOMINAL(NOMINAL)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .errOut     (errOut),
    .errValid   (errValid),
    .rawCapture (rawCapture)
  );

endmodule

// File: tb/pps_freq_err_test.sv
`timescale 1ns/1ps
module pps_freq_err_test;

  localparam int CW  = 12;
  localparam int GN  = 4;
  localparam int NOM = 1000;
  localparam int MAXE = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ppsIn = 1'b0;
  logic signed [CW-1:0] errOut;
  logic errValid;
  logic [CW-1:0] rawCapture;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int edgeT [MAXE];
  int edgeCnt = 0;
  int validCnt = 0;
  int capCnt = 0;
  logic [CW-1:0] prevRaw = '0;
  bit monOn = 1'b0;

  pps_freq_err #(.CNT_W(CW), .GATE_EDGES(GN), .NOMINAL(NOM)) uut (
    .clk(clk), .rst(rst), .ppsIn(ppsIn),
    .errOut(errOut), .errValid(errValid), .rawCapture(rawCapture)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one pulse: rise now, stay high hiLen cycles, period spacing cycles
  task automatic pulse(input int spacing, input int hiLen);
    @(negedge clk);
    ppsIn = 1'b1;
    edgeT[edgeCnt] = cyc;
    edgeCnt++;
    repeat (hiLen) @(negedge clk);
    ppsIn = 1'b0;
    repeat (spacing - hiLen - 1) @(negedge clk);
  endtask

  task automatic doReset();
    monOn = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(errValid == 1'b0, "R7 errValid", int'(errValid), 0);
    check(errOut == '0, "R7 errOut", int'(errOut), 0);
    check(rawCapture == '0, "R7 rawCapture", int'(rawCapture), 0);
    rst = 1'b0;
    edgeCnt = 0; validCnt = 0; capCnt = 0; prevRaw = '0;
    @(negedge clk);
    check(errValid == 1'b0 && rawCapture == '0, "R7 after release", int'(rawCapture), 0);
    monOn = 1'b1;
  endtask

  // monitor: error samples and captures
  always @(negedge clk) begin
    if (monOn && !rst) begin
      if (errValid) begin
        automatic int g = validCnt + 1;
        automatic logic signed [CW-1:0] ee;
        ee = CW'(edgeT[g*GN] - edgeT[(g-1)*GN] - NOM);
        // R5 value, R6 wrap-safe
        check(errOut == ee, "R5/R6 errOut", int'(errOut), int'(ee));
        // R3 / R4: first valid at edge index N, then every N edges
        check(edgeCnt == g*GN + 1, "R3 R4 valid position", edgeCnt, g*GN + 1);
        validCnt++;
      end
      if (rawCapture != prevRaw) begin
        capCnt++;
        if (capCnt >= 2) begin
          automatic logic [CW-1:0] d = rawCapture - prevRaw;
          automatic logic [CW-1:0] ed = CW'(edgeT[capCnt-1] - edgeT[capCnt-2]);
          check(d == ed, "R1 R6 capture spacing", int'(d), int'(ed));
        end
        prevRaw = rawCapture;
      end
    end
  end

  task automatic endPhase();
    repeat (20) @(negedge clk);
    // R2: one capture per rising edge, held-high levels ignored
    check(capCnt == edgeCnt, "R2 capture count", capCnt, edgeCnt);
    check(validCnt == ((edgeCnt > 0) ? (edgeCnt - 1) / GN : 0),
          "R3 valid count", validCnt, (edgeCnt - 1) / GN);
  endtask

  initial begin
    fork
      begin
        doReset();
        // R4: first gate primes only
        for (int i = 0; i < GN; i++) pulse(250, 3);
        check(validCnt == 0, "R4 no valid after first gate", validCnt, 0);
        // exact nominal, error 0
        for (int i = 0; i < 2*GN; i++) pulse(250, 3);
        // fast reference view: more cycles per interval, +4 per gate
        for (int i = 0; i < 2*GN; i++) pulse(251, 5);
        // slow: -8 per gate
        for (int i = 0; i < 2*GN; i++) pulse(248, 2);
        // uneven spacings summing to nominal, long high levels (R2)
        for (int r = 0; r < 2; r++) begin
          pulse(100, 60); pulse(400, 350); pulse(250, 200); pulse(250, 240);
        end
        // large offsets both ways
        for (int i = 0; i < GN; i++) pulse(300, 10);
        for (int i = 0; i < GN; i++) pulse(200, 10);
        // sweep of small per-interval offsets
        for (int k = -3; k <= 3; k++)
          for (int i = 0; i < GN; i++) pulse(250 + k, 4);
        pulse(250, 3);
        endPhase();

        // mid-run reset: priming restarts (R4, R7)
        doReset();
        for (int i = 0; i < GN; i++) pulse(260, 3);
        check(validCnt == 0, "R4 no valid after reset gate", validCnt, 0);
        for (int i = 0; i < 3*GN; i++) pulse(245 + (i % 3) * 5, 7);
        pulse(250, 3);
        endPhase();
      end
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule